// File: doc/BRIEF.md
# SPI Memory Slave Command Front-End

This block is the serial front end of a memory device that acts as an SPI slave. It runs on a fast system clock. It oversamples the serial clock, the active-low chip select, the active-low pause input and the serial data input through two-flop synchronisers, and it detects the serial clock edges internally. After chip select goes low, the first byte is taken as a command code and compared against a set of valid codes that is fixed by a parameter. A valid code is passed to the back end as a one-cycle byte strobe with a flag marking it as the command. Every later complete byte of the frame is passed on in the same way.

An unknown command code locks the interface for the rest of the frame. While locked, no byte is handed on and the serial output stays undriven until chip select goes high and then low again. The back end can queue one byte at any time. That byte is shifted out, most significant bit first, in the next data byte of the frame. While the pause input is low, which is sampled only while the serial clock is low, the transfer is frozen in place.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After reset, `soOe` and `rxValid` are both 0.
- R2: Serial input is sampled on rising serial clock edges, most significant bit first. Each complete byte of an accepted frame produces exactly one `rxValid` pulse, one system clock long, with the assembled byte on `rxByte`.
- R3: `rxIsOpcode` is 1 for the first byte after chip select falls and 0 for every later byte of that frame.
- R4: If the first byte is not in the valid command set, no byte strobe is produced for it or for any later byte, and `soOe` stays 0 for the rest of the frame. The next frame is decoded normally.
- R5: While chip select is high, serial clock and data activity produce no byte strobe, and `soOe` is 0.
- R6: Pause starts when the pause input is low while the serial clock is low, and it ends when the input is high while the clock is low. While paused, `soOe` is 0 and serial clock edges are ignored. The partial byte survives the pause and completes correctly afterwards.
- R7: A byte written with `txLoad` appears on `soOut`, most significant bit first, during the next data byte after the command byte. It changes only on falling serial clock edges. Zeros are shifted out when nothing is queued and during the command byte. While selected, not paused and not locked, `soOe` is 1.
- R8: Both clock polarities are handled: idle-low clock (mode 0) and idle-high clock (mode 3).
- R9: If chip select goes high in the middle of a byte, the partial byte is discarded, and the next frame starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckPin | input | 1 | Serial clock from the master |
| csNPin | input | 1 | Active-low chip select |
| holdNPin | input | 1 | Active-low pause request |
| siPin | input | 1 | Serial data from the master |
| soOut | output | 1 | Serial data to the master |
| soOe | output | 1 | Output enable for soOut (1 = drive) |
| rxValid | output | 1 | One-cycle strobe for a received byte |
| rxByte | output | 8 | Received byte |
| rxIsOpcode | output | 1 | Marks the received byte as the command byte |
| txLoad | input | 1 | Queues txByte for transmission |
| txByte | input | 8 | Byte to transmit in the next data byte |

## Verification
Random frames mix both clock modes, valid and unknown command codes, one to four bytes per frame and optional queued reply bytes. These frames separate correct bit ordering, correct command flagging and correct reply alignment from off-by-one byte boundaries. Directed frames then cover specific cases. A pause in the middle of a byte with the clock toggling must leave the byte intact. Clocking while deselected must produce nothing. A frame aborted after a few bits must not leak into the next frame. An unknown command must silence the rest of its frame without affecting the frame that follows.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef struct packed {
    logic shiftIn;     // rising edge accepted: shift in one bit
    logic emit;        // byte complete and accepted: strobe it
    logic firstByte;   // current byte is the command byte
    logic txBoundary;  // falling edge at a data byte start
    logic txStep;      // falling edge inside a byte
    logic idle;        // chip select high
  } feStrobes_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckPin,
  input  logic csNPin,
  input  logic holdNPin,
  input  logic siPin,
  output logic sckS,
  output logic csS,
  output logic holdS,
  output logic siS,
  output logic sckRise,
  output logic sckFall
);
  localparam int NSIG = 4;
  localparam logic [NSIG-1:0] RST_VAL = 4'b0110; // {sck, cs, hold, si}

  logic [NSIG-1:0] stg [STAGES];
  logic sckD;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[g] <= RST_VAL;
        else if (g == 0) stg[g] <= {sckPin, csNPin, holdNPin, siPin};
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign {sckS, csS, holdS, siS} = stg[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckD <= 1'b0;
    else sckD <= sckS;
  end

  assign sckRise = sckS & ~sckD;
  assign sckFall = ~sckS & sckD;
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
  import spi_fe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckS,
  input  logic       csS,
  input  logic       holdS,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       validOp,
  output feStrobes_t st,
  output logic       active,
  output logic       locked
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] byteCnt;
  logic             paused;
  logic             lastBit;
  logic             firstByte;

  assign active    = !csS && !paused && !locked;
  assign lastBit   = (bitCnt == LAST_BIT);
  assign firstByte = (byteCnt == '0);

  always_comb begin
    st            = '0;
    st.shiftIn    = sckRise && active;
    st.emit       = st.shiftIn && lastBit && !(firstByte && !validOp);
    st.firstByte  = firstByte;
    st.txBoundary = sckFall && active && (bitCnt == '0) && !firstByte;
    st.txStep     = sckFall && active && (bitCnt != '0);
    st.idle       = csS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      paused  <= 1'b0;
      locked  <= 1'b0;
    end else if (csS) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      paused  <= 1'b0;
      locked  <= 1'b0;
    end else begin
      if (!sckS && !locked) paused <= !holdS;
      if (st.shiftIn) begin
        bitCnt <= bitCnt + 1'b1;
        if (lastBit) begin
          if (firstByte && !validOp) locked <= 1'b1;
          if (byteCnt != CNT_MAX) byteCnt <= byteCnt + 1'b1;
        end
      end
    end
  end

  AST_PAUSE_FREEZES_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (paused && $past(paused) && !csS) |-> $stable(bitCnt)); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !csS) |=> (locked || csS)); // R4
  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (bitCnt == '0 && byteCnt == '0)); // R9
endmodule

// File: rtl/spi_fe_datapath.sv
module spi_fe_datapath
  import spi_fe_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_OPS = 6,
  parameter logic [NUM_OPS*BYTE_W-1:0] VALID_OPS = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              siS,
  input  feStrobes_t        st,
  input  logic              txLoad,
  input  logic [BYTE_W-1:0] txByte,
  output logic              validOp,
  output logic              rxValid,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxIsOpcode,
  output logic              soBit
);
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] nextByte;
  logic [BYTE_W-1:0] txHold;
  logic [BYTE_W-1:0] txShift;
  logic              txPend;
  logic [NUM_OPS-1:0] opHit;

  assign nextByte = {rxShift[BYTE_W-2:0], siS};

  genvar g;
  generate
    for (g = 0; g < NUM_OPS; g++) begin : gOpMatch
      assign opHit[g] = (nextByte == VALID_OPS[g*BYTE_W +: BYTE_W]);
    end
  endgenerate
  assign validOp = |opHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift    <= '0;
      rxValid    <= 1'b0;
      rxByte     <= '0;
      rxIsOpcode <= 1'b0;
      txHold     <= '0;
      txShift    <= '0;
      txPend     <= 1'b0;
      soBit      <= 1'b0;
    end else begin
      rxValid <= st.emit;
      if (st.shiftIn) rxShift <= nextByte;
      if (st.emit) begin
        rxByte     <= nextByte;
        rxIsOpcode <= st.firstByte;
      end
      if (st.txBoundary) begin
        if (txPend) begin
          soBit   <= txHold[BYTE_W-1];
          txShift <= {txHold[BYTE_W-2:0], 1'b0};
          txPend  <= 1'b0;
        end else begin
          soBit   <= 1'b0;
          txShift <= '0;
        end
      end else if (st.txStep) begin
        soBit   <= txShift[BYTE_W-1];
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end else if (st.idle) begin
        soBit   <= 1'b0;
        txShift <= '0;
      end
      if (txLoad) begin
        txHold <= txByte;
        txPend <= 1'b1;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R2
  AST_SO_STILL_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    st.shiftIn |=> $stable(soBit)); // R7
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_fe_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int CNT_W   = 4,
  parameter int STAGES  = 2,
  parameter int NUM_OPS = 6,
  parameter logic [NUM_OPS*BYTE_W-1:0] VALID_OPS =
    {8'h03, 8'h0B, 8'h02, 8'h05, 8'h9F, 8'h06}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckPin,
  input  logic              csNPin,
  input  logic              holdNPin,
  input  logic              siPin,
  output logic              soOut,
  output logic              soOe,
  output logic              rxValid,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxIsOpcode,
  input  logic              txLoad,
  input  logic [BYTE_W-1:0] txByte
);
  logic sckS, csS, holdS, siS, sckRise, sckFall;
  logic validOp, active, locked, soBit;
  feStrobes_t st;

  spi_fe_sync #(.STAGES(STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sckPin(sckPin), .csNPin(csNPin),
    .holdNPin(holdNPin), .siPin(siPin), .sckS(sckS), .csS(csS),
    .holdS(holdS), .siS(siS), .sckRise(sckRise), .sckFall(sckFall));

  spi_fe_ctrl #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sckS(sckS), .csS(csS), .holdS(holdS),
    .sckRise(sckRise), .sckFall(sckFall), .validOp(validOp),
    .st(st), .active(active), .locked(locked));

  spi_fe_datapath #(.BYTE_W(BYTE_W), .NUM_OPS(NUM_OPS),
                    .VALID_OPS(VALID_OPS)) uData (
    .clk(clk), .rstN(rstN), .siS(siS), .st(st), .txLoad(txLoad),
    .txByte(txByte), .validOp(validOp), .rxValid(rxValid),
    .rxByte(rxByte), .rxIsOpcode(rxIsOpcode), .soBit(soBit));

  assign soOut = soBit;
  assign soOe  = active;

  AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (csS && $past(csS)) |-> !rxValid); // R5
  AST_LOCKED_NO_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked)) |-> !rxValid); // R4
  AST_NO_OE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csS |-> !soOe); // R5
endmodule

// File: tb/tb_spi_cmd_frontend.sv
module tb_spi_cmd_frontend;
  localparam int H = 6;
  localparam logic [7:0] OPS [6] = '{8'h03, 8'h0B, 8'h02, 8'h05, 8'h9F, 8'h06};

  logic clk = 1'b0, rstN = 1'b0;
  logic sckPin = 1'b0, csNPin = 1'b1, holdNPin = 1'b1, siPin = 1'b0;
  logic soOut, soOe, rxValid, rxIsOpcode, txLoad = 1'b0;
  logic [7:0] rxByte, txByte = 8'h00;

  int checks = 0, failures = 0;
  logic [7:0] recData [256];
  logic       recFirst [256];
  int recCnt = 0;

  logic [7:0] fIn [8];
  logic [7:0] fTx [8];
  bit         fHasTx [8];

  always #2.5 clk = ~clk;

  spi_cmd_frontend dut (
    .clk(clk), .rstN(rstN), .sckPin(sckPin), .csNPin(csNPin),
    .holdNPin(holdNPin), .siPin(siPin), .soOut(soOut), .soOe(soOe),
    .rxValid(rxValid), .rxByte(rxByte), .rxIsOpcode(rxIsOpcode),
    .txLoad(txLoad), .txByte(txByte));

  always @(negedge clk) begin
    if (rxValid && recCnt < 256) begin
      recData[recCnt]  = rxByte;
      recFirst[recCnt] = rxIsOpcode;
      recCnt++;
    end
  end

  function automatic bit isOp(input logic [7:0] b);
    for (int i = 0; i < 6; i++) if (OPS[i] == b) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitH();
    repeat (H) @(negedge clk);
  endtask

  task automatic loadTx(input logic [7:0] b);
    @(negedge clk); txLoad = 1'b1; txByte = b;
    @(negedge clk); txLoad = 1'b0;
  endtask

  // one serial bit; returns sampled so/oe just before the rising edge
  task automatic sendBit(input logic b, input bit pauseHere,
                         output logic so, output logic oe);
    sckPin = 1'b0; waitH();
    if (pauseHere) begin
      holdNPin = 1'b0; waitH();
      for (int t = 0; t < 3; t++) begin
        sckPin = 1'b1; siPin = ~siPin; waitH();
        sckPin = 1'b0; waitH();
        check(soOe == 1'b0, "R6 oe while paused", soOe, 0);
      end
      holdNPin = 1'b1; waitH();
    end
    siPin = b; waitH();
    so = soOut; oe = soOe;
    sckPin = 1'b1; waitH();
  endtask

  task automatic doFrame(input bit mode3, input int n, input int pByte, input int pBit);
    int start;
    bit lock;
    logic so, oe, expBit;
    start = recCnt;
    lock = !isOp(fIn[0]);
    sckPin = mode3; waitH();
    if (n > 1 && fHasTx[1]) loadTx(fTx[1]);
    csNPin = 1'b0; waitH();
    for (int j = 0; j < n; j++) begin
      for (int k = 0; k < 8; k++) begin
        sendBit(fIn[j][7-k], (j == pByte && k == pBit), so, oe);
        if (k == 0 && j + 1 < n && j >= 1 && fHasTx[j+1]) loadTx(fTx[j+1]);
        if (lock && j >= 1) begin
          check(oe == 1'b0, "R4 oe after bad op", oe, 0);
        end else begin
          expBit = (j >= 1 && fHasTx[j]) ? fTx[j][7-k] : 1'b0;
          check(oe == 1'b1, "R7 oe active", oe, 1);
          check(so == expBit, mode3 ? "R7 R8 so bit mode3" : "R7 R8 so bit mode0", so, expBit);
        end
      end
    end
    if (!mode3) begin sckPin = 1'b0; waitH(); end
    csNPin = 1'b1; waitH(); waitH();
    check(soOe == 1'b0, "R5 oe after deselect", soOe, 0);
    if (lock) begin
      check(recCnt == start, "R4 no bytes for bad op", recCnt - start, 0);
    end else begin
      check(recCnt - start == n, "R2 byte count", recCnt - start, n);
      for (int j = 0; j < n && start + j < recCnt; j++) begin
        check(recData[start+j] == fIn[j], "R2 byte value", recData[start+j], fIn[j]);
        check(recFirst[start+j] == (j == 0), "R3 opcode flag", recFirst[start+j], j == 0);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int start;
    logic so, oe;
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    check(soOe == 1'b0, "R1 oe in reset", soOe, 0);
    check(rxValid == 1'b0, "R1 valid in reset", rxValid, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(soOe == 1'b0 && rxValid == 1'b0, "R1 after reset", {soOe, rxValid}, 0);

    // directed: mode 0 and mode 3 with reply bytes
    fIn[0] = 8'h03; fIn[1] = 8'hA5; fIn[2] = 8'h3C;
    fTx[1] = 8'hC3; fHasTx[1] = 1; fTx[2] = 8'h81; fHasTx[2] = 1;
    doFrame(1'b0, 3, -1, -1);
    doFrame(1'b1, 3, -1, -1);

    // R6: pause mid-byte with clock toggling
    fIn[0] = 8'h0B; fIn[1] = 8'h96; fTx[1] = 8'h5A; fHasTx[1] = 1;
    doFrame(1'b0, 2, 1, 3);
    doFrame(1'b1, 2, 1, 5);

    // R5: activity while deselected
    start = recCnt;
    for (int t = 0; t < 20; t++) begin
      sckPin = ~sckPin; siPin = t[0]; waitH();
      check(soOe == 1'b0, "R5 oe deselected", soOe, 0);
    end
    sckPin = 1'b0; waitH();
    check(recCnt == start, "R5 no bytes deselected", recCnt - start, 0);

    // R4: unknown op, then a normal frame
    fIn[0] = 8'hFF; fIn[1] = 8'h06; fIn[2] = 8'h05; fHasTx[1] = 0; fHasTx[2] = 0;
    doFrame(1'b0, 3, -1, -1);
    fIn[0] = 8'h9F; fIn[1] = 8'h12; fHasTx[1] = 0;
    doFrame(1'b1, 2, -1, -1);

    // R9: abort after 5 bits of an op byte, then a normal frame
    start = recCnt;
    csNPin = 1'b0; waitH();
    for (int k = 0; k < 5; k++) sendBit(1'b1, 1'b0, so, oe);
    sckPin = 1'b0; waitH();
    csNPin = 1'b1; waitH(); waitH();
    check(recCnt == start, "R9 partial byte dropped", recCnt - start, 0);
    fIn[0] = 8'h05; fIn[1] = 8'h77; fHasTx[1] = 0;
    doFrame(1'b0, 2, -1, -1);

    // random frames
    for (int f = 0; f < 40; f++) begin
      int n;
      n = 1 + int'($urandom_range(3));
      fIn[0] = ($urandom_range(9) < 8) ? OPS[$urandom_range(5)] : 8'($urandom);
      for (int j = 1; j < 8; j++) begin
        fIn[j] = 8'($urandom);
        fTx[j] = 8'($urandom);
        fHasTx[j] = bit'($urandom_range(1));
      end
      if (!isOp(fIn[0])) for (int j = 1; j < 8; j++) fHasTx[j] = 0;
      doFrame(bit'($urandom_range(1)), n,
              ($urandom_range(3) == 0) ? 1 : -1, int'($urandom_range(7)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule